// File: doc/BRIEF.md
# Sequenced Charge-Pump Clock Controller

This block drives the clocks of two on-chip charge pumps that build the write voltages of a non-volatile memory: one pump makes a negative rail, the other a positive rail. When the write-mode request rises, only the negative pump is clocked. The positive pump gets clocks only after the negative rail has reached its target for the first time. Running the pumps one after the other keeps the inrush current on the shared supply low.

Each rail has a level detector. Its output is high when the rail is at or beyond its target and low when the rail is short of it. The detector gates that rail's pump clock, so the pump runs in bursts that hold the rail at its level. The pump clock is divided down from the system clock. The divider uses a long period while a rail is still ramping and a short period once that rail has reached its target. The block reports the sequencing phase, a ready flag once both rails are up, and a timeout flag if the ramp takes too long.

Top module: `rail_pump_sequencer`

## Requirements
- R1: `phase_o` reports the sequencing phase with the codes 0 = idle, 1 = negative rail ramping, 2 = positive rail ramping and 3 = regulating. Raising `wr_mode_i` moves the phase from 0 to 1. The negative detector reading high moves it from 1 to 2. The positive detector reading high moves it from 2 to 3. Dropping `wr_mode_i` returns it to 0 from any phase. The phase never leaves 0 for any code other than 1.
- R2: `pos_pump_clk_o` shows no pulse while the phase is 0 or 1, so the positive pump never runs before the negative rail has reached its target.
- R3: In write mode, each pump clock runs while its detector input is low. The clock stops once the current period has finished after the detector reads high, and it starts again when the detector returns low.
- R4: Each pump clock has a period of `RAMP_DIV` system clocks until its own rail first reaches target in the current write session, and `STEADY_DIV` clocks after that. A new write session starts again with the ramp period.
- R5: Every pump clock pulse is whole: it is high for exactly half of its period and low for the other half. A period that has started is never cut short.
- R6: `ready_o` is high only when phase 3 is reached and `wr_mode_i` is high. It falls in the same cycle that `wr_mode_i` falls.
- R7: `timeout_o` rises after `TIMEOUT_CYC` clock cycles spent in phases 1 and 2 without reaching phase 3. It stays high while write mode lasts and clears when write mode ends.
- R8: Outside write mode, both pump clocks stay low once any started period has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| wr_mode_i | input | 1 | Write (program or erase) mode request |
| neg_det_i | input | 1 | Negative rail detector, high when at target (asynchronous) |
| pos_det_i | input | 1 | Positive rail detector, high when at target (asynchronous) |
| neg_pump_clk_o | output | 1 | Gated clock to the negative pump |
| pos_pump_clk_o | output | 1 | Gated clock to the positive pump |
| ready_o | output | 1 | Both rails have reached target in this session |
| timeout_o | output | 1 | Ramp did not finish within the allowed cycles |
| phase_o | output | 2 | Sequencing phase code |

## Verification
The bench holds the negative detector low and checks that the positive clock stays silent. A design that started both pumps together would show a positive pulse there. The bench measures the period and high time of each clock before and after its rail reaches target, and again after a fresh write entry. A divider that fails to switch, or that keeps the steady period into the next session, gives the wrong count. The bench raises each detector during a burst and then watches a quiet window. Gating that cuts the current period short, or that never resumes, shows up as a short pulse or a missing restart. The bench also drops write mode and samples `ready_o` before the next edge, and it holds both rails low to bracket the timeout cycle.

// File: rtl/rail_pump_pkg.sv
package rail_pump_pkg;

    typedef enum logic [1:0] {
        PH_IDLE     = 2'd0,
        PH_NEG_RAMP = 2'd1,
        PH_POS_RAMP = 2'd2,
        PH_REGULATE = 2'd3
    } pump_phase_e;

    typedef struct packed {
        logic run;
        logic steady;
    } rail_ctl_t;

    localparam int unsigned NUM_RAILS = 2;
    localparam int unsigned RAIL_NEG  = 0;
    localparam int unsigned RAIL_POS  = 1;

    function automatic int unsigned cnt_width(input int unsigned max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction

endpackage

// File: rtl/det_sync.sv
module det_sync #(
    parameter int unsigned WIDTH  = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    stage_q[s] <= '0;
                end else begin
                    if (s == 0) stage_q[s] <= async_i;
                    else        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/pump_clk_gen.sv
module pump_clk_gen
    import rail_pump_pkg::*;
#(
    parameter int unsigned RAMP_DIV   = 8,
    parameter int unsigned STEADY_DIV = 4
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  rail_ctl_t ctl_i,
    output logic      pclk_o
);
    localparam int unsigned CW = cnt_width(RAMP_DIV - 1);
    localparam logic [CW-1:0] RP_LAST = CW'(RAMP_DIV - 1);
    localparam logic [CW-1:0] ST_LAST = CW'(STEADY_DIV - 1);
    localparam logic [CW-1:0] RP_HALF = CW'(RAMP_DIV / 2);
    localparam logic [CW-1:0] ST_HALF = CW'(STEADY_DIV / 2);

    logic          run_q, run_d;
    logic          st_q, st_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          pclk_q, pclk_d;
    logic [CW-1:0] last_cur, half_nxt;

    // The run and period choice are loaded only at the end of a low phase,
    // or while the clock is parked low.
    always_comb begin
        run_d    = run_q;
        st_d     = st_q;
        cnt_d    = cnt_q;
        last_cur = st_q ? ST_LAST : RP_LAST;
        if (!run_q) begin
            cnt_d = '0;
            if (ctl_i.run) begin
                run_d = 1'b1;
                st_d  = ctl_i.steady;
            end
        end else if (cnt_q == last_cur) begin
            cnt_d = '0;
            run_d = ctl_i.run;
            st_d  = ctl_i.steady;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
        half_nxt = st_d ? ST_HALF : RP_HALF;
        pclk_d   = run_d && (cnt_d < half_nxt);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            run_q  <= 1'b0;
            st_q   <= 1'b0;
            cnt_q  <= '0;
            pclk_q <= 1'b0;
        end else begin
            run_q  <= run_d;
            st_q   <= st_d;
            cnt_q  <= cnt_d;
            pclk_q <= pclk_d;
        end
    end

    assign pclk_o = pclk_q;
endmodule

// File: rtl/pump_seq_ctrl.sv
module pump_seq_ctrl
    import rail_pump_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic                            clk_i,
    input  logic                            rst_i,
    input  logic                            wr_mode_i,
    input  logic [NUM_RAILS-1:0]            det_i,
    output rail_ctl_t [NUM_RAILS-1:0]       ctl_o,
    output pump_phase_e                     phase_o,
    output logic                            ready_o,
    output logic                            timeout_o
);
    localparam int unsigned TW = cnt_width(TIMEOUT_CYC);
    localparam logic [TW-1:0] TO_LAST = TW'(TIMEOUT_CYC - 1);

    pump_phase_e ph_q, ph_d;
    logic [TW-1:0] to_cnt_q;
    logic          to_flag_q;
    logic          ramping, neg_done;

    always_comb begin
        ph_d = ph_q;
        unique case (ph_q)
            PH_IDLE:     if (wr_mode_i)         ph_d = PH_NEG_RAMP;
            PH_NEG_RAMP: if (!wr_mode_i)        ph_d = PH_IDLE;
                         else if (det_i[RAIL_NEG]) ph_d = PH_POS_RAMP;
            PH_POS_RAMP: if (!wr_mode_i)        ph_d = PH_IDLE;
                         else if (det_i[RAIL_POS]) ph_d = PH_REGULATE;
            PH_REGULATE: if (!wr_mode_i)        ph_d = PH_IDLE;
            default:                            ph_d = PH_IDLE;
        endcase
    end

    assign ramping  = (ph_q == PH_NEG_RAMP) || (ph_q == PH_POS_RAMP);
    assign neg_done = (ph_q == PH_POS_RAMP) || (ph_q == PH_REGULATE);

    always_comb begin
        ctl_o[RAIL_NEG].run    = wr_mode_i && (ph_q != PH_IDLE) && !det_i[RAIL_NEG];
        ctl_o[RAIL_NEG].steady = neg_done;
        ctl_o[RAIL_POS].run    = wr_mode_i && neg_done && !det_i[RAIL_POS];
        ctl_o[RAIL_POS].steady = (ph_q == PH_REGULATE);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ph_q      <= PH_IDLE;
            to_cnt_q  <= '0;
            to_flag_q <= 1'b0;
        end else begin
            ph_q <= ph_d;
            if (!wr_mode_i || ph_q == PH_IDLE) begin
                to_cnt_q  <= '0;
                to_flag_q <= 1'b0;
            end else if (ramping && !to_flag_q) begin
                if (to_cnt_q == TO_LAST) to_flag_q <= 1'b1;
                else                     to_cnt_q  <= to_cnt_q + TW'(1);
            end
        end
    end

    assign phase_o   = ph_q;
    assign ready_o   = wr_mode_i && (ph_q == PH_REGULATE);
    assign timeout_o = to_flag_q;
endmodule

// File: rtl/rail_pump_sequencer.sv
module rail_pump_sequencer
    import rail_pump_pkg::*;
#(
    parameter int unsigned RAMP_DIV    = 8,
    parameter int unsigned STEADY_DIV  = 4,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       wr_mode_i,
    input  logic       neg_det_i,
    input  logic       pos_det_i,
    output logic       neg_pump_clk_o,
    output logic       pos_pump_clk_o,
    output logic       ready_o,
    output logic       timeout_o,
    output logic [1:0] phase_o
);
    logic [NUM_RAILS-1:0]      det_raw, det_s, pclk;
    rail_ctl_t [NUM_RAILS-1:0] ctl;
    pump_phase_e               phase;

    assign det_raw[RAIL_NEG] = neg_det_i;
    assign det_raw[RAIL_POS] = pos_det_i;

    det_sync #(.WIDTH(NUM_RAILS), .STAGES(SYNC_STAGES)) u_sync (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .async_i (det_raw),
        .sync_o  (det_s)
    );

    pump_seq_ctrl #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_ctrl (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .wr_mode_i (wr_mode_i),
        .det_i     (det_s),
        .ctl_o     (ctl),
        .phase_o   (phase),
        .ready_o   (ready_o),
        .timeout_o (timeout_o)
    );

    generate
        for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
            pump_clk_gen #(.RAMP_DIV(RAMP_DIV), .STEADY_DIV(STEADY_DIV)) u_clk (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .ctl_i  (ctl[r]),
                .pclk_o (pclk[r])
            );
        end
    endgenerate

    assign neg_pump_clk_o = pclk[RAIL_NEG];
    assign pos_pump_clk_o = pclk[RAIL_POS];
    assign phase_o        = phase;
endmodule

// File: rtl/rail_pump_checker.sv
module rail_pump_checker (
    input logic       clk_i,
    input logic       rst_i,
    input logic       wr_mode_i,
    input logic       neg_pump_clk_o,
    input logic       pos_pump_clk_o,
    input logic       ready_o,
    input logic       timeout_o,
    input logic [1:0] phase_o
);
    p_phase_entry_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        (phase_o == 2'd0) |=> (phase_o == 2'd0 || phase_o == 2'd1));

    p_pos_after_neg_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(pos_pump_clk_o) |-> (phase_o == 2'd2 || phase_o == 2'd3));

    p_neg_whole_high_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $rose(neg_pump_clk_o) |=> neg_pump_clk_o);

    p_pos_whole_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        $fell(pos_pump_clk_o) |=> !pos_pump_clk_o);

    p_ready_regulate_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        ready_o |-> (wr_mode_i && phase_o == 2'd3));

    p_timeout_sticky_r7: assert property (@(posedge clk_i) disable iff (rst_i)
        (timeout_o && wr_mode_i) |=> timeout_o);
endmodule

bind rail_pump_sequencer rail_pump_checker u_chk (
    .clk_i          (clk_i),
    .rst_i          (rst_i),
    .wr_mode_i      (wr_mode_i),
    .neg_pump_clk_o (neg_pump_clk_o),
    .pos_pump_clk_o (pos_pump_clk_o),
    .ready_o        (ready_o),
    .timeout_o      (timeout_o),
    .phase_o        (phase_o)
);

// File: tb/rail_pump_sequencer_tb.sv
module rail_pump_sequencer_tb;
    localparam int RAMP = 8;
    localparam int STDY = 4;
    localparam int TO   = 1024;

    logic clk = 1'b0, rst = 1'b1, wr = 1'b0, ndet = 1'b0, pdet = 1'b0;
    logic nclk, pclk, ready, tout;
    logic [1:0] phase;
    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    rail_pump_sequencer #(.RAMP_DIV(RAMP), .STEADY_DIV(STDY), .TIMEOUT_CYC(TO)) u_dut (
        .clk_i(clk), .rst_i(rst), .wr_mode_i(wr), .neg_det_i(ndet), .pos_det_i(pdet),
        .neg_pump_clk_o(nclk), .pos_pump_clk_o(pclk), .ready_o(ready),
        .timeout_o(tout), .phase_o(phase));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic rail_clk(input int r);
        return (r == 0) ? nclk : pclk;
    endfunction

    // counts pulses seen on a rail over n cycles
    task automatic count_pulses(input int r, input int n, output int pulses);
        logic prev = rail_clk(r);
        pulses = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (rail_clk(r) && !prev) pulses++;
            prev = rail_clk(r);
        end
    endtask

    task automatic measure(input int r, output int per, output int hi);
        logic prev = rail_clk(r);
        int lim = 0;
        logic in_low = 1'b0;
        per = -1; hi = -1;
        while (!(rail_clk(r) && !prev) && lim < 100) begin
            prev = rail_clk(r); @(negedge clk); lim++;
        end
        for (int c = 1; c < 100; c++) begin
            @(negedge clk);
            if (!rail_clk(r) && !in_low) begin hi = c; in_low = 1'b1; end
            else if (rail_clk(r) && in_low) begin per = c; break; end
        end
    endtask

    task automatic t_reset();
        cyc(4); rst = 1'b0; cyc(2);
        chk("R1 reset phase", int'(phase), 0);
        chk("R6 reset ready", int'(ready), 0);
        chk("R7 reset timeout", int'(tout), 0);
        chk("R8 reset clocks", int'(nclk | pclk), 0);
    endtask

    task automatic t_neg_ramp();
        int per, hi, pulses;
        ndet = 1'b0; pdet = 1'b0; wr = 1'b1;
        cyc(2);
        chk("R1 entry phase", int'(phase), 1);
        measure(0, per, hi);
        chk("R4 neg ramp period", per, RAMP);
        chk("R5 neg ramp high time", hi, RAMP/2);
        count_pulses(1, 40, pulses);
        chk("R2 pos silent during neg ramp", pulses, 0);
    endtask

    task automatic t_pos_ramp();
        int per, hi, pulses;
        ndet = 1'b1; cyc(4);
        chk("R1 neg reached phase", int'(phase), 2);
        chk("R6 not ready in pos ramp", int'(ready), 0);
        measure(1, per, hi);
        chk("R4 pos ramp period", per, RAMP);
        chk("R5 pos ramp high time", hi, RAMP/2);
        count_pulses(0, 20, pulses);
        chk("R3 neg stopped at target", pulses, 0);
    endtask

    task automatic t_regulate();
        int per, hi, pulses;
        pdet = 1'b1; cyc(4);
        chk("R1 regulate phase", int'(phase), 3);
        chk("R6 ready in regulate", int'(ready), 1);
        cyc(12);
        count_pulses(1, 20, pulses);
        chk("R3 pos stopped at target", pulses, 0);
        ndet = 1'b0;
        measure(0, per, hi);
        chk("R4 neg steady period", per, STDY);
        chk("R5 neg steady high time", hi, STDY/2);
        ndet = 1'b1; pdet = 1'b0;
        measure(1, per, hi);
        chk("R3 pos resumes below target", int'(per > 0), 1);
        chk("R4 pos steady period", per, STDY);
        chk("R1 phase held in regulate", int'(phase), 3);
        pdet = 1'b1;
    endtask

    task automatic t_exit();
        int pn, pp;
        wr = 1'b0; ndet = 1'b0; pdet = 1'b0;
        #1;
        chk("R6 ready drops with write", int'(ready), 0);
        cyc(2);
        chk("R1 exit phase", int'(phase), 0);
        cyc(12);
        count_pulses(0, 30, pn);
        count_pulses(1, 30, pp);
        chk("R8 neg idle outside write", pn, 0);
        chk("R8 pos idle outside write", pp, 0);
    endtask

    task automatic t_reentry();
        int per, hi;
        wr = 1'b1; cyc(2);
        chk("R1 reentry phase", int'(phase), 1);
        measure(0, per, hi);
        chk("R4 ramp period after reentry", per, RAMP);
        wr = 1'b0; cyc(20);
    endtask

    task automatic t_timeout();
        wr = 1'b1;
        cyc(TO - 20);
        chk("R7 no early timeout", int'(tout), 0);
        cyc(40);
        chk("R7 timeout raised", int'(tout), 1);
        ndet = 1'b1; cyc(30);
        chk("R7 timeout held in write", int'(tout), 1);
        wr = 1'b0; cyc(2);
        chk("R7 timeout cleared on exit", int'(tout), 0);
    endtask

    initial begin
        t_reset();
        t_neg_ramp();
        t_pos_ramp();
        t_regulate();
        t_exit();
        t_reentry();
        ndet = 1'b0; pdet = 1'b0;
        t_timeout();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        cyc(150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule